// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This unit turns fault reports from a five-stage in-order pipeline into a precise trap. The decode stage can report an illegal encoding and the execute stage can report an arithmetic overflow. Each report comes with the PC of the instruction that raised it. If both arrive in the same cycle, the unit takes the one from the older instruction, which is the one in execute.

In the cycle of the trap, the unit kills the faulting instruction and every younger one, and it sends fetch to a handler. Instructions older than the faulting one are left to complete. On the next clock edge the unit saves two values: the faulting PC plus four, and a one-bit reason code.

A mode input chooses how the handler address is formed. In fixed mode there is a single entry point. In vectored mode there is one entry per reason, and the entries are a fixed stride apart. A separate return request sends fetch back to the saved address and leaves the saved state as it was.

Top module: `exc_ctrl`

## Requirements
- R1: While reset is low and right after it is released, the saved return address reads 0 and the reason code reads 0.
- R2: A decode fault with no execute fault asserts `redirect_o`, `kill_if_o` and `kill_id_o`, leaves `kill_ex_o` low, and stores reason code 0 at the next edge.
- R3: An execute overflow asserts `redirect_o`, `kill_if_o`, `kill_id_o` and `kill_ex_o`, and stores reason code 1 at the next edge.
- R4: When a decode fault and an execute overflow are raised together, the execute one is taken. The reason code becomes 1 and the saved address is derived from `ex_pc_i`.
- R5: At the edge after a trap, the saved return address equals the faulting PC plus 4, computed modulo 2^32.
- R6: With `vec_mode_i` = 0, the trap target is 0x80000180 for either reason.
- R7: With `vec_mode_i` = 1, the trap target is 0xC0000000 + reason × 0x20. That gives 0xC0000000 for a decode fault and 0xC0000020 for an overflow.
- R8: A return request with no fault asserts `redirect_o` and drives the saved address on `redirect_pc_o`. It raises no kill signal, and the saved address and reason code stay unchanged.
- R9: A fault raised in the same cycle as a return request wins. The trap target, the kills and the register update follow R2 to R7.
- R10: With no fault and no return request, `redirect_o` and all kill outputs are low, and the saved state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vec_mode_i | input | 1 | 0 selects the single handler entry, 1 selects per-reason entries |
| id_undef_i | input | 1 | Decode stage holds an illegal encoding |
| id_pc_i | input | 32 | PC of the decode-stage instruction |
| ex_ovf_i | input | 1 | Execute stage produced an arithmetic overflow |
| ex_pc_i | input | 32 | PC of the execute-stage instruction |
| ret_i | input | 1 | Return-from-handler request |
| redirect_o | output | 1 | Fetch must load `redirect_pc_o` |
| redirect_pc_o | output | 32 | New fetch address |
| kill_if_o | output | 1 | Turn the fetch-stage contents into a bubble |
| kill_id_o | output | 1 | Turn the decode-stage contents into a bubble |
| kill_ex_o | output | 1 | Turn the execute-stage contents into a bubble |
| epc_o | output | 32 | Saved return address |
| cause_o | output | 1 | Saved reason code (0 illegal encoding, 1 overflow) |

## Verification
The bench uses the default parameters: a 32-bit PC, a fixed entry at 0x80000180, a vector base of 0xC0000000 and a stride of 0x20. With these values the exact target addresses in R6 and R7 can be checked, and so can the wrap of the PC-plus-4 adder when the faulting PC is 0xFFFFFFFC. Because the rows of the stimulus table run in sequence, each return request reads back the address saved by the trap before it. This lets the bench check the priority rules for simultaneous faults and for a fault together with a return.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // Reason code; the value 0/1 is architecturally visible.
  typedef enum logic [0:0] {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } exc_cause_e;

  // Per-stage kill request, oldest stage in the least significant position.
  typedef struct packed {
    logic if_s;
    logic id_s;
    logic ex_s;
  } kill_t;
endpackage

// File: rtl/exc_select.sv
module exc_select
  import exc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            id_undef_i,
  input  logic [XLEN-1:0] id_pc_i,
  input  logic            ex_ovf_i,
  input  logic [XLEN-1:0] ex_pc_i,
  output logic            take_o,
  output exc_cause_e      cause_o,
  output logic [XLEN-1:0] pc_o,
  output kill_t           kill_o
);
  // Execute holds the older instruction, so its fault outranks decode.
  always_comb begin
    take_o  = ex_ovf_i | id_undef_i;
    cause_o = CAUSE_UNDEF;
    pc_o    = id_pc_i;
    kill_o  = '0;
    if (ex_ovf_i) begin
      cause_o = CAUSE_OVF;
      pc_o    = ex_pc_i;
      kill_o  = '{if_s: 1'b1, id_s: 1'b1, ex_s: 1'b1};
    end else if (id_undef_i) begin
      kill_o  = '{if_s: 1'b1, id_s: 1'b1, ex_s: 1'b0};
    end
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] FIXED_ADDR = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STEP   = 32'h0000_0020
) (
  input  logic            vec_mode_i,
  input  exc_cause_e      cause_i,
  output logic [XLEN-1:0] target_o
);
  function automatic logic [XLEN-1:0] handler_addr(input logic vec, input exc_cause_e c);
    logic [XLEN-1:0] idx;
    idx = XLEN'(c);
    return vec ? (VEC_BASE + idx * VEC_STEP) : FIXED_ADDR;
  endfunction

  assign target_o = handler_addr(vec_mode_i, cause_i);
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [XLEN-1:0] pc_i,
  input  exc_cause_e      cause_i,
  output logic [XLEN-1:0] epc_o,
  output exc_cause_e      cause_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  function automatic logic [XLEN-1:0] next_epc(input logic [XLEN-1:0] pc);
    return pc + STEP;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_o   <= '0;
      cause_o <= CAUSE_UNDEF;
    end else if (load_i) begin
      epc_o   <= next_epc(pc_i);
      cause_o <= cause_i;
    end
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] FIXED_ADDR = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STEP   = 32'h0000_0020
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vec_mode_i,
  input  logic            id_undef_i,
  input  logic [XLEN-1:0] id_pc_i,
  input  logic            ex_ovf_i,
  input  logic [XLEN-1:0] ex_pc_i,
  input  logic            ret_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            kill_if_o,
  output logic            kill_id_o,
  output logic            kill_ex_o,
  output logic [XLEN-1:0] epc_o,
  output logic            cause_o
);
  // Named internal events for the checks below.
  logic            take;
  exc_cause_e      sel_cause;
  logic [XLEN-1:0] sel_pc;
  kill_t           kill;
  logic [XLEN-1:0] handler_pc;
  exc_cause_e      cause_q;
  logic            ret_only;

  exc_select #(.XLEN(XLEN)) u_sel (
    .id_undef_i (id_undef_i),
    .id_pc_i    (id_pc_i),
    .ex_ovf_i   (ex_ovf_i),
    .ex_pc_i    (ex_pc_i),
    .take_o     (take),
    .cause_o    (sel_cause),
    .pc_o       (sel_pc),
    .kill_o     (kill)
  );

  exc_target #(
    .XLEN(XLEN), .FIXED_ADDR(FIXED_ADDR), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_tgt (
    .vec_mode_i (vec_mode_i),
    .cause_i    (sel_cause),
    .target_o   (handler_pc)
  );

  exc_state #(.XLEN(XLEN)) u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (take),
    .pc_i    (sel_pc),
    .cause_i (sel_cause),
    .epc_o   (epc_o),
    .cause_o (cause_q)
  );

  assign cause_o       = cause_q;
  assign ret_only      = ret_i & ~take;
  assign redirect_o    = take | ret_i;
  assign redirect_pc_o = take ? handler_pc : epc_o;
  assign kill_if_o     = kill.if_s;
  assign kill_id_o     = kill.id_s;
  assign kill_ex_o     = kill.ex_s;

  p_undef_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (id_undef_i && !ex_ovf_i) |-> (!kill_ex_o && kill_id_o) ##1 (cause_o == 1'b0));
  p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf_i |=> (cause_o == 1'b1));
  p_ex_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_ovf_i && id_undef_i) |=> (epc_o == $past(ex_pc_i) + XLEN'(4)));
  p_epc_plus4_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (id_undef_i && !ex_ovf_i) |=> (epc_o == $past(id_pc_i) + XLEN'(4)));
  p_fixed_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ex_ovf_i || id_undef_i) && !vec_mode_i) |-> (redirect_pc_o == FIXED_ADDR));
  p_ret_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_only |=> ($stable(epc_o) && $stable(cause_o)));
  p_ret_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_only |-> (redirect_o && redirect_pc_o == epc_o && !kill_if_o));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_i && !id_undef_i && !ex_ovf_i) |-> (!redirect_o && !kill_if_o && !kill_ex_o));
endmodule

// File: tb/sim_exc_ctrl.sv
module sim_exc_ctrl;
  typedef struct packed {
    logic [3:0]  req;
    logic        mode;
    logic        undef;
    logic [31:0] id_pc;
    logic        ovf;
    logic [31:0] ex_pc;
    logic        ret;
    logic        e_redir;
    logic [31:0] e_rpc;
    logic [2:0]  e_kill;   // {if, id, ex}
    logic [31:0] e_epc;
    logic        e_cause;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{4'd10, 1'b0, 1'b0, 32'h100,      1'b0, 32'h0FC,      1'b0, 1'b0, 32'h0,         3'b000, 32'h0,    1'b0}, // R10 idle
    '{4'd6,  1'b0, 1'b1, 32'h40,       1'b0, 32'h3C,       1'b0, 1'b1, 32'h8000_0180, 3'b110, 32'h44,   1'b0}, // R6 R2
    '{4'd8,  1'b0, 1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 1'b1, 32'h44,        3'b000, 32'h44,   1'b0}, // R8
    '{4'd3,  1'b0, 1'b0, 32'h50,       1'b1, 32'h4C,       1'b0, 1'b1, 32'h8000_0180, 3'b111, 32'h50,   1'b1}, // R3 R5
    '{4'd7,  1'b1, 1'b1, 32'h1000,     1'b0, 32'hFFC,      1'b0, 1'b1, 32'hC000_0000, 3'b110, 32'h1004, 1'b0}, // R7 undef
    '{4'd7,  1'b1, 1'b0, 32'h2004,     1'b1, 32'h2000,     1'b0, 1'b1, 32'hC000_0020, 3'b111, 32'h2004, 1'b1}, // R7 ovf
    '{4'd4,  1'b1, 1'b1, 32'h3008,     1'b1, 32'h3004,     1'b0, 1'b1, 32'hC000_0020, 3'b111, 32'h3008, 1'b1}, // R4 vectored
    '{4'd4,  1'b0, 1'b1, 32'h50,       1'b1, 32'h4C,       1'b0, 1'b1, 32'h8000_0180, 3'b111, 32'h50,   1'b1}, // R4 fixed
    '{4'd9,  1'b1, 1'b1, 32'h600,      1'b0, 32'h5FC,      1'b1, 1'b1, 32'hC000_0000, 3'b110, 32'h604,  1'b0}, // R9
    '{4'd8,  1'b1, 1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 1'b1, 32'h604,       3'b000, 32'h604,  1'b0}, // R8 vectored
    '{4'd10, 1'b1, 1'b0, 32'h700,      1'b0, 32'h6FC,      1'b0, 1'b0, 32'h0,         3'b000, 32'h604,  1'b0}, // R10
    '{4'd5,  1'b0, 1'b0, 32'h0,        1'b1, 32'hFFFF_FFFC,1'b0, 1'b1, 32'h8000_0180, 3'b111, 32'h0,    1'b1}, // R5 wrap
    '{4'd8,  1'b0, 1'b0, 32'h0,        1'b0, 32'h0,        1'b1, 1'b1, 32'h0,         3'b000, 32'h0,    1'b1}  // R8 after wrap
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vec_mode_i = 1'b0, id_undef_i = 1'b0, ex_ovf_i = 1'b0, ret_i = 1'b0;
  logic [31:0] id_pc_i = '0, ex_pc_i = '0;
  logic        redirect_o, kill_if_o, kill_id_o, kill_ex_o, cause_o;
  logic [31:0] redirect_pc_o, epc_o;

  int n_chk = 0;
  int n_ok  = 0;

  always #2 clk = ~clk;   // 250 MHz

  exc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .vec_mode_i(vec_mode_i),
    .id_undef_i(id_undef_i), .id_pc_i(id_pc_i),
    .ex_ovf_i(ex_ovf_i), .ex_pc_i(ex_pc_i), .ret_i(ret_i),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .kill_if_o(kill_if_o), .kill_id_o(kill_id_o), .kill_ex_o(kill_ex_o),
    .epc_o(epc_o), .cause_o(cause_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act === exp) n_ok++;
    else $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  endtask

  task automatic drive(input logic m, input logic u, input logic [31:0] ip,
                       input logic o, input logic [31:0] ep, input logic r);
    vec_mode_i = m; id_undef_i = u; id_pc_i = ip; ex_ovf_i = o; ex_pc_i = ep; ret_i = r;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    string tag;
    // R1: reset state
    #5;
    chk("R1", "epc in reset", epc_o, 32'h0);
    chk("R1", "cause in reset", {31'b0, cause_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "epc after release", epc_o, 32'h0);
    chk("R1", "cause after release", {31'b0, cause_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      tag = $sformatf("R%0d row %0d", TBL[i].req, i);
      drive(TBL[i].mode, TBL[i].undef, TBL[i].id_pc, TBL[i].ovf, TBL[i].ex_pc, TBL[i].ret);
      #1;
      chk(tag, "redirect", {31'b0, redirect_o}, {31'b0, TBL[i].e_redir});
      if (TBL[i].e_redir) chk(tag, "target", redirect_pc_o, TBL[i].e_rpc);
      chk(tag, "kills", {29'b0, kill_if_o, kill_id_o, kill_ex_o}, {29'b0, TBL[i].e_kill});
      @(posedge clk); #1;
      chk(tag, "epc", epc_o, TBL[i].e_epc);
      chk(tag, "cause", {31'b0, cause_o}, {31'b0, TBL[i].e_cause});
      @(negedge clk);
    end

    // R3 directed: overflow in vectored mode from a fresh address, then reset clears it (R1)
    drive(1'b1, 1'b0, 32'h0, 1'b1, 32'h700, 1'b0);
    @(posedge clk); #1;
    chk("R3", "cause set", {31'b0, cause_o}, 32'h1);
    chk("R5", "epc 0x700+4", epc_o, 32'h704);
    @(negedge clk);
    drive(1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
    rst_n = 1'b0; #1;
    chk("R1", "epc cleared by reset", epc_o, 32'h0);
    chk("R1", "cause cleared by reset", {31'b0, cause_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    // R8: return after reset goes to the cleared address
    drive(1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1); #1;
    chk("R8", "return target after reset", redirect_pc_o, 32'h0);
    @(negedge clk);
    drive(1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    finish_run();
  end
endmodule